// File: doc/BRIEF.md
# MIDI UART Host Port with Command Acknowledge

This block gives a host a two-register window onto a serial MIDI link. Address 0 is the byte data register: host writes queue a byte for transmission and host reads take the oldest received byte. Address 1 is the command register on write and the status register on read. The port runs only as a plain UART. It honours two command codes, and each one answers with an acknowledge byte delivered through the receive path. The port ignores every other command code.

Behind the window there is a transmit queue that feeds an 8N1 serializer, and a deserializer that feeds a receive queue. The bit period is a parameterized number of clock cycles; for 31250 baud from a 50 MHz clock it is 1600. Two level interrupt outputs tell the host that the transmit queue has drained and that received data is waiting. Each interrupt has its own enable input. A sticky flag records received bytes lost to a full receive queue.

Top module: `midi_uart_port`

## Requirements
- R1: After reset the status register reads 0x80, `midi_tx` is high, `rx_overrun` is 0, `rx_irq` is 0, and `tx_irq` equals `tx_irq_en`.
- R2: Writing 0xFF to address 1 discards all queued receive data, clears `rx_overrun`, and leaves exactly one byte 0xFE to be read from address 0.
- R3: Writing 0x3F to address 1 appends 0xFE to the receive queue. It lands behind bytes that were already received and ahead of bytes received later.
- R4: Writing any code other than 0xFF or 0x3F to address 1 changes neither the receive queue nor the status.
- R5: Status bit 7 reads 0 exactly when a byte can be read from address 0. Status bit 6 reads 0 exactly when the transmit queue has room. Status bits 5..0 read 0.
- R6: Each transmitted byte is sent as a low start bit, then eight data bits with the least significant bit first, then a high stop bit. Each bit lasts CLK_DIV cycles, and the line idles high.
- R7: A correctly framed byte on `midi_rx` becomes readable at address 0. Host reads of address 0 return bytes in arrival order and remove them. A read of an empty queue returns 0x00.
- R8: A frame whose stop bit samples low is discarded. Reception resumes with the next frame that follows an idle-high line.
- R9: A byte that completes while RX_DEPTH bytes are already queued is dropped and sets `rx_overrun`. The flag stays set until reset or a 0xFF command, and the queued bytes are kept.
- R10: While a byte is being shifted out, the transmit queue holds TX_DEPTH more bytes. Writes to address 0 when the queue is full are discarded.
- R11: `tx_irq` is high exactly when `tx_irq_en` is high and the transmit queue is empty. `rx_irq` is high exactly when `rx_irq_en` is high and a byte is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs | input | 1 | Host access select |
| host_wr | input | 1 | Host write strobe (with host_cs) |
| host_rd | input | 1 | Host read strobe (with host_cs); reading address 0 removes a byte |
| host_addr | input | 1 | 0 = data register, 1 = command/status register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the addressed register |
| rx_irq_en | input | 1 | Enable for the received-data interrupt |
| tx_irq_en | input | 1 | Enable for the transmit-empty interrupt |
| rx_irq | output | 1 | Received-data interrupt |
| tx_irq | output | 1 | Transmit-queue-empty interrupt |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| midi_rx | input | 1 | Serial MIDI input |
| midi_tx | output | 1 | Serial MIDI output |

## Verification
If a queue pointer or count is wrong, the status byte disagrees with the number of reads that return data. This shows on the next status read after the access that went wrong. If the deserializer state or the bit counter is wrong, a byte comes back corrupted or shifted within one frame time. The full 256-value loopback sweep would expose it. Ordering faults between an acknowledge and MIDI data show up as a swapped byte sequence on the reads that follow a command.

// File: rtl/midi_uart_pkg.sv
package midi_uart_pkg;
   localparam logic [7:0] CMD_RESET = 8'hFF;
   localparam logic [7:0] CMD_UART  = 8'h3F;
   localparam logic [7:0] CMD_ACK   = 8'hFE;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_BREAK
   } rx_state_t;
endpackage

// File: rtl/midi_byte_fifo.sv
module midi_byte_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          full
);
   if (DEPTH < 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("midi_byte_fifo: DEPTH must be a power of two");
   end

   if (DEPTH == 1) begin : g_single
      logic          vld;
      logic [DW-1:0] dat;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld <= 1'b0;
            dat <= '0;
         end else if (flush || (push && !vld)) begin
            vld <= push;
            if (push) dat <= wdata;
         end else if (pop) begin
            vld <= 1'b0;
         end
      end
      assign head  = dat;
      assign empty = !vld;
      assign full  = vld;
   end else begin : g_ring
      localparam int AW = $clog2(DEPTH);
      localparam int CW = $clog2(DEPTH + 1);
      logic [DW-1:0] mem [DEPTH];
      logic [AW-1:0] wp, rp;
      logic [CW-1:0] cnt;
      logic          do_push, do_pop;

      assign do_push = push && (flush || cnt != CW'(DEPTH));
      assign do_pop  = pop && cnt != '0 && !flush;

      always_ff @(posedge clk) begin
         if (do_push) mem[flush ? '0 : wp] <= wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
         end else if (flush) begin
            rp  <= '0;
            wp  <= push ? AW'(1) : '0;
            cnt <= push ? CW'(1) : '0;
         end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
         end
      end
      assign head  = mem[rp];
      assign empty = (cnt == '0);
      assign full  = (cnt == CW'(DEPTH));
   end
endmodule

// File: rtl/midi_tx_ser.sv
module midi_tx_ser #(
   parameter int CLK_DIV = 1600
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       avail,
   input  logic [7:0] data,
   output logic       take,
   output logic       busy,
   output logic       line
);
   localparam int DCW = $clog2(CLK_DIV);

   logic [9:0]     sh;
   logic [3:0]     bitn;
   logic [DCW-1:0] div;

   assign take = !busy && avail;
   assign line = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         bitn <= '0;
         div  <= '0;
         busy <= 1'b0;
      end else if (take) begin
         sh   <= {1'b1, data, 1'b0};
         bitn <= '0;
         div  <= '0;
         busy <= 1'b1;
      end else if (busy) begin
         if (div == DCW'(CLK_DIV - 1)) begin
            div <= '0;
            if (bitn == 4'd9) begin
               busy <= 1'b0;
            end else begin
               sh   <= {1'b1, sh[9:1]};
               bitn <= bitn + 4'd1;
            end
         end else begin
            div <= div + DCW'(1);
         end
      end
   end
endmodule

// File: rtl/midi_rx_des.sv
module midi_rx_des
   import midi_uart_pkg::*;
#(
   parameter int CLK_DIV = 1600
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line,
   output logic       valid,
   output logic [7:0] data
);
   localparam int DCW  = $clog2(CLK_DIV);
   localparam int HALF = CLK_DIV / 2;

   logic [1:0]     sync;
   logic           lvl;
   rx_state_t      st;
   logic [DCW-1:0] div;
   logic [2:0]     bitn;
   logic [7:0]     sh;

   assign lvl = sync[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync  <= 2'b11;
         st    <= RX_IDLE;
         div   <= '0;
         bitn  <= '0;
         sh    <= '0;
         valid <= 1'b0;
         data  <= '0;
      end else begin
         sync  <= {sync[0], line};
         valid <= 1'b0;
         unique case (st)
            RX_IDLE: if (!lvl) begin
               st  <= RX_START;
               div <= '0;
            end
            RX_START: if (div == DCW'(HALF - 1)) begin
               div  <= '0;
               bitn <= '0;
               st   <= lvl ? RX_IDLE : RX_DATA;
            end else div <= div + DCW'(1);
            RX_DATA: if (div == DCW'(CLK_DIV - 1)) begin
               div <= '0;
               sh  <= {lvl, sh[7:1]};
               if (bitn == 3'd7) st <= RX_STOP;
               else bitn <= bitn + 3'd1;
            end else div <= div + DCW'(1);
            RX_STOP: if (div == DCW'(CLK_DIV - 1)) begin
               div <= '0;
               if (lvl) begin
                  valid <= 1'b1;
                  data  <= sh;
                  st    <= RX_IDLE;
               end else st <= RX_BREAK;
            end else div <= div + DCW'(1);
            RX_BREAK: if (lvl) st <= RX_IDLE;
            default: st <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/midi_uart_port.sv
module midi_uart_port
   import midi_uart_pkg::*;
#(
   parameter int CLK_DIV  = 1600,
   parameter int RX_DEPTH = 4,
   parameter int TX_DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_cs,
   input  logic       host_wr,
   input  logic       host_rd,
   input  logic       host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   input  logic       rx_irq_en,
   input  logic       tx_irq_en,
   output logic       rx_irq,
   output logic       tx_irq,
   output logic       rx_overrun,
   input  logic       midi_rx,
   output logic       midi_tx
);
   if (CLK_DIV < 4) begin : g_bad_div
      $error("midi_uart_port: CLK_DIV must be at least 4");
   end

   logic       wr_data, wr_cmd, rd_data;
   logic       cmd_reset, cmd_ack;
   logic       rx_empty, rx_full, tx_empty, tx_full;
   logic [7:0] rx_head, tx_head;
   logic       tx_take, tx_busy;
   logic       des_valid;
   logic [7:0] des_data;
   logic       rx_pend_vld;
   logic [7:0] rx_pend_data;
   logic       rx_push;
   logic [7:0] rx_pdata;

   assign wr_data   = host_cs && host_wr && !host_addr;
   assign wr_cmd    = host_cs && host_wr && host_addr;
   assign rd_data   = host_cs && host_rd && !host_addr;
   assign cmd_reset = wr_cmd && host_wdata == CMD_RESET;
   assign cmd_ack   = cmd_reset || (wr_cmd && host_wdata == CMD_UART);

   // acknowledge wins the push slot; a received byte waits one cycle
   assign rx_push  = cmd_ack || rx_pend_vld;
   assign rx_pdata = cmd_ack ? CMD_ACK : rx_pend_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_pend_vld  <= 1'b0;
         rx_pend_data <= '0;
         rx_overrun   <= 1'b0;
      end else begin
         if (des_valid) begin
            rx_pend_vld  <= 1'b1;
            rx_pend_data <= des_data;
         end else if (rx_pend_vld && !cmd_ack) begin
            rx_pend_vld <= 1'b0;
         end
         if (cmd_reset) rx_overrun <= 1'b0;
         else if (rx_pend_vld && !cmd_ack && rx_full) rx_overrun <= 1'b1;
      end
   end

   midi_byte_fifo #(.DW(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(cmd_reset), .push(rx_push),
      .wdata(rx_pdata), .pop(rd_data), .head(rx_head),
      .empty(rx_empty), .full(rx_full)
   );

   midi_byte_fifo #(.DW(8), .DEPTH(TX_DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(1'b0), .push(wr_data),
      .wdata(host_wdata), .pop(tx_take), .head(tx_head),
      .empty(tx_empty), .full(tx_full)
   );

   midi_tx_ser #(.CLK_DIV(CLK_DIV)) u_tx (
      .clk(clk), .rst_n(rst_n), .avail(!tx_empty), .data(tx_head),
      .take(tx_take), .busy(tx_busy), .line(midi_tx)
   );

   midi_rx_des #(.CLK_DIV(CLK_DIV)) u_rx (
      .clk(clk), .rst_n(rst_n), .line(midi_rx),
      .valid(des_valid), .data(des_data)
   );

   always_comb begin
      if (host_addr) host_rdata = {rx_empty, tx_full, 6'b0};
      else           host_rdata = rx_empty ? 8'h00 : rx_head;
   end

   assign rx_irq = rx_irq_en && !rx_empty;
   assign tx_irq = tx_irq_en && tx_empty;
endmodule

// File: rtl/midi_uart_port_chk.sv
module midi_uart_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       host_cs,
   input logic       host_wr,
   input logic       host_addr,
   input logic [7:0] host_wdata,
   input logic       rx_irq_en,
   input logic       tx_irq_en,
   input logic       rx_irq,
   input logic       tx_irq,
   input logic       rx_overrun,
   input logic       midi_tx,
   input logic       rx_empty,
   input logic       rx_pend_vld,
   input logic       tx_busy
);
   logic cmd_wr;
   assign cmd_wr = host_cs && host_wr && host_addr;

   p_reset_cmd_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && host_wdata == 8'hFF) |=> !rx_empty);

   p_ignored_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && host_wdata != 8'hFF && host_wdata != 8'h3F && rx_empty && !rx_pend_vld)
      |=> rx_empty);

   p_line_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> midi_tx);

   p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overrun && !(cmd_wr && host_wdata == 8'hFF)) |=> rx_overrun);

   p_rx_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_irq_en |-> !rx_irq);

   p_tx_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_irq_en |-> !tx_irq);
endmodule

bind midi_uart_port midi_uart_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
   .host_addr(host_addr), .host_wdata(host_wdata),
   .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en),
   .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_overrun(rx_overrun),
   .midi_tx(midi_tx), .rx_empty(rx_empty), .rx_pend_vld(rx_pend_vld),
   .tx_busy(tx_busy)
);

// File: tb/midi_uart_port_bench.sv
module midi_uart_port_bench;
   localparam int DIV  = 8;
   localparam int RXD  = 8;
   localparam int TXD  = 4;
   localparam int HALF = DIV / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_cs = 1'b0, host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       rx_irq_en = 1'b1, tx_irq_en = 1'b1;
   logic       rx_irq, tx_irq, rx_overrun;
   logic       midi_tx, midi_rx;
   logic       bench_rx = 1'b1;
   logic       loop = 1'b0;
   int         compared = 0, mismatched = 0, cycles = 0;
   bit         done = 1'b0;

   assign midi_rx = loop ? midi_tx : bench_rx;

   always #10 clk = ~clk;

   midi_uart_port #(.CLK_DIV(DIV), .RX_DEPTH(RXD), .TX_DEPTH(TXD)) u_midi_uart_port (
      .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
      .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en),
      .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_overrun(rx_overrun),
      .midi_rx(midi_rx), .midi_tx(midi_tx)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      compared++;
      if (got !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hwrite(input logic a, input logic [7:0] d);
      host_cs = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_cs = 1'b0; host_wr = 1'b0;
   endtask

   task automatic hread(input logic a, output logic [7:0] d);
      host_cs = 1'b1; host_rd = 1'b1; host_addr = a;
      #1 d = host_rdata;
      @(negedge clk);
      host_cs = 1'b0; host_rd = 1'b0;
   endtask

   task automatic send_rx(input logic [7:0] b, input logic stop);
      logic [9:0] fr;
      fr = {stop, b, 1'b0};
      for (int i = 0; i < 10; i++) begin
         bench_rx = fr[i];
         wait_cyc(DIV);
      end
      bench_rx = 1'b1;
      wait_cyc(3 * DIV);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles >= 200000 && !done) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: actual %0d expected below 200000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] exp_b;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);

      // R1 reset state
      hread(1'b1, d); chk("R1 status", d, 8'h80);
      chk("R1 midi_tx", {7'b0, midi_tx}, 8'h01);
      chk("R1 overrun", {7'b0, rx_overrun}, 8'h00);
      chk("R1 rx_irq", {7'b0, rx_irq}, 8'h00);
      chk("R1 tx_irq", {7'b0, tx_irq}, 8'h01);

      // R4 sweep of every ignored command code
      for (int c = 0; c < 256; c++) begin
         if (c != 8'hFF && c != 8'h3F) begin
            hwrite(1'b1, 8'(c));
            wait_cyc(1);
            hread(1'b1, d); chk("R4 status after ignored cmd", d, 8'h80);
         end
      end
      hread(1'b0, d); chk("R7 empty read", d, 8'h00);

      // R2 reset command acknowledge
      hwrite(1'b1, 8'hFF);
      hread(1'b1, d); chk("R2 R5 status ack waiting", d, 8'h00);
      hread(1'b0, d); chk("R2 ack byte", d, 8'hFE);
      hread(1'b1, d); chk("R2 R5 status drained", d, 8'h80);

      // R6 transmit framing
      for (int k = 0; k < 3; k++) begin
         exp_b = (k == 0) ? 8'hA5 : (k == 1) ? 8'h01 : 8'h80;
         hwrite(1'b0, exp_b);
         while (midi_tx) @(negedge clk);
         wait_cyc(HALF);
         chk("R6 start bit", {7'b0, midi_tx}, 8'h00);
         for (int b = 0; b < 8; b++) begin
            wait_cyc(DIV);
            chk("R6 data bit", {7'b0, midi_tx}, {7'b0, exp_b[b]});
         end
         wait_cyc(DIV);
         chk("R6 stop bit", {7'b0, midi_tx}, 8'h01);
         wait_cyc(DIV);
      end
      hread(1'b1, d); chk("R6 no echo without loop", d, 8'h80);

      // R7 loopback sweep of all byte values, R11 rx interrupt
      loop = 1'b1;
      for (int v = 0; v < 256; v++) begin
         hwrite(1'b0, 8'(v));
         wait_cyc(12 * DIV + 6);
         chk("R11 rx_irq with data", {7'b0, rx_irq}, 8'h01);
         hread(1'b0, d); chk("R7 loopback byte", d, 8'(v));
      end
      hread(1'b1, d); chk("R7 R5 status after sweep", d, 8'h80);

      // R10 transmit queue capacity
      for (int i = 0; i < TXD + 2; i++) hwrite(1'b0, 8'(8'h10 + i));
      hread(1'b1, d); chk("R10 R5 status tx full", d, 8'hC0);
      chk("R11 tx_irq busy", {7'b0, tx_irq}, 8'h00);
      wait_cyc((TXD + 2) * (10 * DIV + 2) + 40);
      for (int i = 0; i < TXD + 1; i++) begin
         hread(1'b0, d); chk("R10 queued byte", d, 8'(8'h10 + i));
      end
      hread(1'b1, d); chk("R10 extra byte dropped", d, 8'h80);
      chk("R11 tx_irq empty", {7'b0, tx_irq}, 8'h01);
      loop = 1'b0;
      wait_cyc(2);

      // R3 acknowledge ordering
      send_rx(8'h42, 1'b1);
      hwrite(1'b1, 8'h3F);
      send_rx(8'h17, 1'b1);
      hread(1'b0, d); chk("R3 earlier byte", d, 8'h42);
      hread(1'b0, d); chk("R3 ack", d, 8'hFE);
      hread(1'b0, d); chk("R3 later byte", d, 8'h17);
      hread(1'b1, d); chk("R3 status drained", d, 8'h80);

      // R8 framing error
      send_rx(8'h55, 1'b0);
      wait_cyc(2 * DIV);
      hread(1'b1, d); chk("R8 bad frame dropped", d, 8'h80);
      send_rx(8'h66, 1'b1);
      hread(1'b0, d); chk("R8 recovery byte", d, 8'h66);

      // R9 overrun
      for (int i = 0; i < RXD; i++) send_rx(8'(i * 7 + 3), 1'b1);
      chk("R9 no overrun at capacity", {7'b0, rx_overrun}, 8'h00);
      send_rx(8'hEE, 1'b1);
      chk("R9 overrun set", {7'b0, rx_overrun}, 8'h01);
      for (int i = 0; i < RXD; i++) begin
         hread(1'b0, d); chk("R9 kept byte", d, 8'(i * 7 + 3));
      end
      hread(1'b1, d); chk("R9 lost byte absent", d, 8'h80);
      chk("R9 overrun sticky", {7'b0, rx_overrun}, 8'h01);
      send_rx(8'h21, 1'b1);
      hwrite(1'b1, 8'hFF);
      chk("R2 overrun cleared", {7'b0, rx_overrun}, 8'h00);
      hread(1'b0, d); chk("R2 flush then ack", d, 8'hFE);
      hread(1'b1, d); chk("R2 only ack", d, 8'h80);

      // R11 interrupt enables
      send_rx(8'h33, 1'b1);
      chk("R11 rx_irq enabled", {7'b0, rx_irq}, 8'h01);
      rx_irq_en = 1'b0; tx_irq_en = 1'b0;
      wait_cyc(1);
      chk("R11 rx_irq disabled", {7'b0, rx_irq}, 8'h00);
      chk("R11 tx_irq disabled", {7'b0, tx_irq}, 8'h00);
      rx_irq_en = 1'b1; tx_irq_en = 1'b1;
      hread(1'b0, d); chk("R7 byte behind disabled irq", d, 8'h33);
      chk("R11 rx_irq drained", {7'b0, rx_irq}, 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule